// File: doc/BRIEF.md
# Bandwidth-Limited Memory Responder

This block is a memory target with a small word-addressed backing array. Requests arrive on a valid/ready channel. Each one is a read or a write with a size in bytes, a flag saying whether a response is wanted, and an extra transport delay. Responses leave on a separate valid/ready channel. The target caps its short-term data rate: an accepted request keeps it busy for a number of cycles proportional to its size. A request that arrives during that window is refused. The target remembers that it owes the requester a retry, and it raises a one-cycle retry strobe once the window closes.

Each response gets a due time in cycles. The due time is the transport delay, plus a fixed base latency, plus a bounded pseudo-random extra term. Responses wait in an eight-entry queue kept in due-time order. A new response is never placed ahead of an older one to the same address, and never ahead of the current head. When the head is due it is offered. If the receiver refuses it, the head stays in place and is not offered again until the receiver sends a retry strobe. A drained output shows that no response is pending.

Top module: `bwmem_responder`

## Requirements
- R1: Command code 2'b01 is a read and 2'b10 is a write. A request that carries 2'b00 or 2'b11 while `reqReady` is high is consumed without touching the array, the queue or the busy timer, and `cmdError` is high for exactly the following cycle.
- R2: `reqReady` is high exactly when the busy timer is idle, no retry is owed and the queue holds fewer than QDEPTH entries. A refused request changes nothing in the array or the queue. A refusal while a retry is already owed leaves all state as it was.
- R3: A request refused while the busy timer runs and no retry is owed records that a retry is owed.
- R4: An accepted legal request of size S holds `reqReady` low for the S×BYTE_COST cycles after its acceptance cycle. A size of zero never starts the busy timer.
- R5: In the first cycle after the busy window closes, `retryReq` is high for one cycle if a retry was owed, counting a refusal in the last busy cycle, and the owed flag is cleared.
- R6: A cycle counter starts at 0 in the first cycle after reset. A response is due at counter + `reqDelay` + BASE_LAT + extra, taken in the acceptance cycle. The extra term is the LFSR value modulo (LAT_VAR+1), or 0 when LAT_VAR is 0. The 16-bit LFSR is seeded 0xACE1 at reset and shifts left every cycle. Its new bit 0 is the XOR of bits 15, 13, 12 and 10.
- R7: A write updates the array in its acceptance cycle. A queued read returns the array word before that cycle's write, and a queued write returns the written data with `rspIsWrite` high. Requests with `reqNeedResp` low create no queue entry.
- R8: A new entry is placed by scanning from the tail toward the entry behind the head. It stops at the first entry whose due time is not later than its own or whose address matches, and the new entry goes just behind that entry. If no entry stops the scan, it goes directly behind the head. An empty queue takes it as head.
- R9: `rspValid` is high when the head is due and no refusal is pending. A cycle with `rspValid` high and `rspReady` low is a refusal: the head is kept and `rspValid` stays low until the cycle after `rspRetry` is seen.
- R10: `drained` is high exactly when the response queue is empty.
- R11: With QDEPTH entries queued, every request is refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Request accepted this cycle |
| reqCmd | input | 2 | Command code |
| reqAddr | input | ADDR_W | Word address |
| reqWdata | input | DATA_W | Write data |
| reqSize | input | SIZE_W | Request size in bytes |
| reqNeedResp | input | 1 | Response wanted |
| reqDelay | input | DELAY_W | Transport delay in cycles added to the due time |
| retryReq | output | 1 | One-cycle strobe: resend the refused request |
| cmdError | output | 1 | One-cycle strobe: illegal command consumed |
| rspValid | output | 1 | Response offered |
| rspReady | input | 1 | Receiver takes the offered response |
| rspAddr | output | ADDR_W | Response address |
| rspData | output | DATA_W | Response data |
| rspIsWrite | output | 1 | Response belongs to a write |
| rspRetry | input | 1 | Receiver asks for the refused response again |
| drained | output | 1 | No response pending |

## Verification
Two pairs of functions can fall in the same cycle. A new entry can be inserted while the head leaves the queue. The busy window can close in the cycle that a late refusal arrives. The random phase keeps requests asserted across refusals and draws `rspReady` randomly, so both collisions happen many times. A behavioural model built on lists and integers predicts every port on every cycle. Directed sequences then check the full queue, the address-ordering rule and the response retry path against hand-derived orders and durations.

// File: rtl/bwmem_pkg.sv
`timescale 1ns/1ps
package bwmem_pkg;
  localparam int TIME_W = 16;

  typedef enum logic [1:0] {
    CMD_NONE  = 2'b00,
    CMD_READ  = 2'b01,
    CMD_WRITE = 2'b10,
    CMD_RSVD  = 2'b11
  } memCmdT;

  typedef struct packed {
    logic doAccess;
    logic doWrite;
    logic doPush;
    logic doPop;
  } memStrobeT;

  // true when "now" has reached "due", wrap-safe over half the counter range
  function automatic logic timeReached(input logic [TIME_W-1:0] due,
                                       input logic [TIME_W-1:0] now);
    logic [TIME_W-1:0] diff;
    diff = now - due;
    return ~diff[TIME_W-1];
  endfunction
endpackage

// File: rtl/bwmem_ctrl.sv
`timescale 1ns/1ps
module bwmem_ctrl
  import bwmem_pkg::*;
#(
  parameter int SIZE_W    = 4,
  parameter int BYTE_COST = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [1:0]        reqCmd,
  input  logic [SIZE_W-1:0] reqSize,
  input  logic              reqNeedResp,
  input  logic              qFull,
  input  logic              headDue,
  input  logic              rspReady,
  input  logic              rspRetry,
  output logic              reqReady,
  output logic              retryReq,
  output logic              cmdError,
  output logic              rspValid,
  output logic              busy,
  output memStrobeT         strobe
);
  localparam int MAX_BUSY = ((1 << SIZE_W) - 1) * BYTE_COST;
  localparam int BUSY_W   = $clog2(MAX_BUSY + 2);

  logic [BUSY_W-1:0] busyCnt;
  logic [BUSY_W-1:0] busyLoad;
  logic retryOwed;
  logic waitRetry;
  logic cmdLegal;
  logic accept;
  logic busyEnd;
  logic refuseBusy;
  logic owedPre;

  assign cmdLegal   = (reqCmd == CMD_READ) || (reqCmd == CMD_WRITE);
  assign busy       = (busyCnt != '0);
  assign reqReady   = !busy && !retryOwed && !qFull;
  assign accept     = reqValid && reqReady;
  assign busyLoad   = BUSY_W'(reqSize) * BUSY_W'(BYTE_COST);
  assign busyEnd    = (busyCnt == BUSY_W'(1));
  assign refuseBusy = reqValid && busy && !retryOwed;
  assign owedPre    = retryOwed || refuseBusy;
  assign rspValid   = headDue && !waitRetry;

  always_comb begin
    strobe          = '0;
    strobe.doAccess = accept && cmdLegal;
    strobe.doWrite  = accept && (reqCmd == CMD_WRITE);
    strobe.doPush   = accept && cmdLegal && reqNeedResp;
    strobe.doPop    = rspValid && rspReady;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyCnt   <= '0;
      retryOwed <= 1'b0;
      retryReq  <= 1'b0;
      cmdError  <= 1'b0;
      waitRetry <= 1'b0;
    end else begin
      if (strobe.doAccess && (busyLoad != '0)) begin
        busyCnt <= busyLoad;
      end else if (busy) begin
        busyCnt <= busyCnt - BUSY_W'(1);
      end

      if (busyEnd) begin
        retryOwed <= 1'b0;
        retryReq  <= owedPre;
      end else begin
        retryOwed <= owedPre;
        retryReq  <= 1'b0;
      end

      cmdError <= accept && !cmdLegal;

      if (rspValid && !rspReady) begin
        waitRetry <= 1'b1;
      end else if (rspRetry) begin
        waitRetry <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/bwmem_datapath.sv
`timescale 1ns/1ps
module bwmem_datapath
  import bwmem_pkg::*;
#(
  parameter int          ADDR_W    = 4,
  parameter int          DATA_W    = 32,
  parameter int          DELAY_W   = 8,
  parameter int          BASE_LAT  = 4,
  parameter int          LAT_VAR   = 5,
  parameter int          QDEPTH    = 8,
  parameter logic [15:0] LFSR_SEED = 16'hACE1
) (
  input  logic               clk,
  input  logic               rstN,
  input  memStrobeT          strobe,
  input  logic [ADDR_W-1:0]  reqAddr,
  input  logic [DATA_W-1:0]  reqWdata,
  input  logic [DELAY_W-1:0] reqDelay,
  output logic               qFull,
  output logic               qEmpty,
  output logic               headDue,
  output logic [ADDR_W-1:0]  rspAddr,
  output logic [DATA_W-1:0]  rspData,
  output logic               rspIsWrite
);
  localparam int ENT_W = TIME_W + ADDR_W + DATA_W + 1;
  localparam int CNT_W = $clog2(QDEPTH + 1);
  localparam int WORDS = 1 << ADDR_W;

  logic [TIME_W-1:0] nowCnt;
  logic [15:0]       lfsr;
  logic [TIME_W-1:0] extraLat;
  logic [TIME_W-1:0] newRdy;
  logic [DATA_W-1:0] memArr [WORDS];
  logic [DATA_W-1:0] newData;
  logic [ENT_W-1:0]  newEnt;
  logic [ENT_W-1:0]  qEnt    [QDEPTH];
  logic [ENT_W-1:0]  insEnt  [QDEPTH+1];
  logic [ENT_W-1:0]  nextEnt [QDEPTH];
  logic [CNT_W-1:0]  qCount;
  logic [CNT_W-1:0]  insPos;

  function automatic logic [TIME_W-1:0] entRdy(input logic [ENT_W-1:0] e);
    return e[ENT_W-1 -: TIME_W];
  endfunction
  function automatic logic [ADDR_W-1:0] entAddr(input logic [ENT_W-1:0] e);
    return e[DATA_W+1 +: ADDR_W];
  endfunction

  generate
    if (LAT_VAR == 0) begin : g_fixed_lat
      assign extraLat = '0;
    end else begin : g_rand_lat
      assign extraLat = TIME_W'(lfsr % 16'(LAT_VAR + 1));
    end
  endgenerate

  assign newRdy  = nowCnt + TIME_W'(reqDelay) + TIME_W'(BASE_LAT) + extraLat;
  assign newData = strobe.doWrite ? reqWdata : memArr[reqAddr];
  assign newEnt  = {newRdy, reqAddr, newData, strobe.doWrite};

  assign qFull      = (qCount == CNT_W'(QDEPTH));
  assign qEmpty     = (qCount == '0);
  assign headDue    = !qEmpty && timeReached(entRdy(qEnt[0]), nowCnt);
  assign rspAddr    = entAddr(qEnt[0]);
  assign rspData    = qEnt[0][1 +: DATA_W];
  assign rspIsWrite = qEnt[0][0];

  // tail-to-head scan; the head slot is never passed
  always_comb begin
    insPos = qEmpty ? '0 : CNT_W'(1);
    for (int i = 1; i < QDEPTH; i++) begin
      if ((CNT_W'(i) < qCount) &&
          (timeReached(entRdy(qEnt[i]), newRdy) || (entAddr(qEnt[i]) == reqAddr))) begin
        insPos = CNT_W'(i + 1);
      end
    end
  end

  generate
    for (genvar j = 0; j <= QDEPTH; j++) begin : g_ins
      if (j == 0) begin : g_head
        assign insEnt[j] = (strobe.doPush && (insPos == '0)) ? newEnt : qEnt[0];
      end else if (j == QDEPTH) begin : g_spill
        assign insEnt[j] = !strobe.doPush ? '0 :
                           (insPos == CNT_W'(j)) ? newEnt : qEnt[j-1];
      end else begin : g_mid
        assign insEnt[j] = !strobe.doPush ? qEnt[j] :
                           (insPos == CNT_W'(j)) ? newEnt :
                           (insPos < CNT_W'(j)) ? qEnt[j-1] : qEnt[j];
      end
    end
    for (genvar k = 0; k < QDEPTH; k++) begin : g_next
      assign nextEnt[k] = strobe.doPop ? insEnt[k+1] : insEnt[k];
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nowCnt <= '0;
      lfsr   <= LFSR_SEED;
      qCount <= '0;
      for (int i = 0; i < QDEPTH; i++) qEnt[i] <= '0;
    end else begin
      nowCnt <= nowCnt + TIME_W'(1);
      lfsr   <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      qCount <= qCount + CNT_W'(strobe.doPush) - CNT_W'(strobe.doPop);
      for (int i = 0; i < QDEPTH; i++) qEnt[i] <= nextEnt[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < WORDS; i++) memArr[i] <= '0;
    end else if (strobe.doWrite) begin
      memArr[reqAddr] <= reqWdata;
    end
  end
endmodule

// File: rtl/bwmem_responder.sv
`timescale 1ns/1ps
module bwmem_responder
  import bwmem_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 32,
  parameter int SIZE_W    = 4,
  parameter int DELAY_W   = 8,
  parameter int BYTE_COST = 2,
  parameter int BASE_LAT  = 4,
  parameter int LAT_VAR   = 5,
  parameter int QDEPTH    = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  output logic               reqReady,
  input  logic [1:0]         reqCmd,
  input  logic [ADDR_W-1:0]  reqAddr,
  input  logic [DATA_W-1:0]  reqWdata,
  input  logic [SIZE_W-1:0]  reqSize,
  input  logic               reqNeedResp,
  input  logic [DELAY_W-1:0] reqDelay,
  output logic               retryReq,
  output logic               cmdError,
  output logic               rspValid,
  input  logic               rspReady,
  output logic [ADDR_W-1:0]  rspAddr,
  output logic [DATA_W-1:0]  rspData,
  output logic               rspIsWrite,
  input  logic               rspRetry,
  output logic               drained
);
  memStrobeT strobe;
  logic qFull;
  logic qEmpty;
  logic headDue;
  logic busy;

  bwmem_ctrl #(
    .SIZE_W    (SIZE_W),
    .BYTE_COST (BYTE_COST)
  ) ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .reqCmd      (reqCmd),
    .reqSize     (reqSize),
    .reqNeedResp (reqNeedResp),
    .qFull       (qFull),
    .headDue     (headDue),
    .rspReady    (rspReady),
    .rspRetry    (rspRetry),
    .reqReady    (reqReady),
    .retryReq    (retryReq),
    .cmdError    (cmdError),
    .rspValid    (rspValid),
    .busy        (busy),
    .strobe      (strobe)
  );

  bwmem_datapath #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .DELAY_W  (DELAY_W),
    .BASE_LAT (BASE_LAT),
    .LAT_VAR  (LAT_VAR),
    .QDEPTH   (QDEPTH)
  ) dpath_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .reqAddr    (reqAddr),
    .reqWdata   (reqWdata),
    .reqDelay   (reqDelay),
    .qFull      (qFull),
    .qEmpty     (qEmpty),
    .headDue    (headDue),
    .rspAddr    (rspAddr),
    .rspData    (rspData),
    .rspIsWrite (rspIsWrite)
  );

  assign drained = qEmpty;
endmodule

// File: rtl/bwmem_checker.sv
`timescale 1ns/1ps
module bwmem_checker #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int SIZE_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic [1:0]        reqCmd,
  input logic [SIZE_W-1:0] reqSize,
  input logic              qFull,
  input logic              busy,
  input logic              retryReq,
  input logic              cmdError,
  input logic              rspValid,
  input logic              rspReady,
  input logic [ADDR_W-1:0] rspAddr,
  input logic [DATA_W-1:0] rspData,
  input logic              drained
);
  logic badCmd;
  assign badCmd = (reqCmd == 2'b00) || (reqCmd == 2'b11);

  a_r1_bad_cmd_flag: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady && badCmd |=> cmdError);

  a_r1_flag_cause: assert property (@(posedge clk) disable iff (!rstN)
    cmdError |-> $past(reqValid && reqReady && badCmd));

  a_r2_busy_refuses: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !reqReady);

  a_r4_size_sets_busy: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady && !badCmd && (reqSize != '0) |=> !reqReady);

  a_r4_zero_size_free: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady && (reqSize == '0) && drained |=> reqReady);

  a_r5_retry_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    retryReq |=> !retryReq);

  a_r5_retry_opens: assert property (@(posedge clk) disable iff (!rstN)
    retryReq && !qFull |-> reqReady);

  a_r9_refused_silent: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && !rspReady |=> !rspValid);

  a_r9_head_kept: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && !rspReady |=> $stable(rspAddr) && $stable(rspData));

  a_r10_empty_idle: assert property (@(posedge clk) disable iff (!rstN)
    drained |-> !rspValid);

  a_r11_full_refuses: assert property (@(posedge clk) disable iff (!rstN)
    qFull |-> !reqReady);
endmodule

bind bwmem_responder bwmem_checker #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .SIZE_W (SIZE_W)
) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .reqValid (reqValid),
  .reqReady (reqReady),
  .reqCmd   (reqCmd),
  .reqSize  (reqSize),
  .qFull    (qFull),
  .busy     (busy),
  .retryReq (retryReq),
  .cmdError (cmdError),
  .rspValid (rspValid),
  .rspReady (rspReady),
  .rspAddr  (rspAddr),
  .rspData  (rspData),
  .drained  (drained)
);

// File: tb/bwmem_responder_tb.sv
`timescale 1ns/1ps
module bwmem_responder_tb_top;
  localparam int ADDR_W    = 4;
  localparam int DATA_W    = 32;
  localparam int SIZE_W    = 4;
  localparam int DELAY_W   = 8;
  localparam int BYTE_COST = 2;
  localparam int BASE_LAT  = 4;
  localparam int LAT_VAR   = 5;
  localparam int QDEPTH    = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic               rstN;
  logic               reqValid;
  logic               reqReady;
  logic [1:0]         reqCmd;
  logic [ADDR_W-1:0]  reqAddr;
  logic [DATA_W-1:0]  reqWdata;
  logic [SIZE_W-1:0]  reqSize;
  logic               reqNeedResp;
  logic [DELAY_W-1:0] reqDelay;
  logic               retryReq;
  logic               cmdError;
  logic               rspValid;
  logic               rspReady;
  logic [ADDR_W-1:0]  rspAddr;
  logic [DATA_W-1:0]  rspData;
  logic               rspIsWrite;
  logic               rspRetry;
  logic               drained;

  bwmem_responder #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SIZE_W(SIZE_W), .DELAY_W(DELAY_W),
    .BYTE_COST(BYTE_COST), .BASE_LAT(BASE_LAT), .LAT_VAR(LAT_VAR), .QDEPTH(QDEPTH)
  ) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqCmd(reqCmd), .reqAddr(reqAddr), .reqWdata(reqWdata), .reqSize(reqSize),
    .reqNeedResp(reqNeedResp), .reqDelay(reqDelay), .retryReq(retryReq),
    .cmdError(cmdError), .rspValid(rspValid), .rspReady(rspReady),
    .rspAddr(rspAddr), .rspData(rspData), .rspIsWrite(rspIsWrite),
    .rspRetry(rspRetry), .drained(drained)
  );

  // ---------------- behavioural reference model ----------------
  typedef struct {
    logic [15:0]       rdy;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
    logic              wr;
  } entT;

  entT         mq[$];
  logic [DATA_W-1:0] mMem [16];
  int          mBusy;
  bit          mOwed, mRetry, mErr, mWait;
  logic [15:0] mNow, mLfsr;

  int  checks = 0;
  int  fails  = 0;
  bit  autoRsp = 1'b1;
  bit  done = 1'b0;
  int  sawRetry = 0, sawErr = 0, sawRefuse = 0;

  function automatic bit le16(input logic [15:0] a, input logic [15:0] b);
    logic [15:0] d;
    d = b - a;
    return !d[15];
  endfunction

  function automatic bit mReady();
    return (mBusy == 0) && !mOwed && (mq.size() < QDEPTH);
  endfunction

  function automatic bit mRspValid();
    if (mq.size() == 0) return 1'b0;
    return le16(mq[0].rdy, mNow) && !mWait;
  endfunction

  task automatic chk(input bit ok, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", what, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    bit ev;
    ev = mRspValid();
    chk(reqReady == mReady(), "R2 R4 R11 reqReady", 64'(reqReady), 64'(mReady()));
    chk(rspValid == ev, "R6 R9 rspValid", 64'(rspValid), 64'(ev));
    if (ev && rspValid) begin
      chk(rspAddr == mq[0].addr, "R8 rspAddr", 64'(rspAddr), 64'(mq[0].addr));
      chk(rspData == mq[0].data, "R7 rspData", 64'(rspData), 64'(mq[0].data));
      chk(rspIsWrite == mq[0].wr, "R7 rspIsWrite", 64'(rspIsWrite), 64'(mq[0].wr));
    end
    chk(retryReq == mRetry, "R3 R5 retryReq", 64'(retryReq), 64'(mRetry));
    chk(cmdError == mErr, "R1 cmdError", 64'(cmdError), 64'(mErr));
    chk(drained == (mq.size() == 0), "R10 drained", 64'(drained), 64'(mq.size() == 0));
    if (retryReq) sawRetry++;
    if (cmdError) sawErr++;
  endtask

  task automatic modelStep();
    bit acc, legal, rv, busyNow, endNow, refuse, owedPre;
    entT e;
    int p;
    logic [15:0] extra;
    rv      = mRspValid();
    acc     = reqValid && mReady();
    legal   = (reqCmd == 2'b01) || (reqCmd == 2'b10);
    busyNow = (mBusy != 0);
    endNow  = (mBusy == 1);
    refuse  = reqValid && busyNow && !mOwed;
    owedPre = mOwed || refuse;
    extra   = (LAT_VAR == 0) ? 16'd0 : (mLfsr % 16'(LAT_VAR + 1));
    if (acc && legal) begin
      e.rdy  = 16'(mNow + 16'(reqDelay) + 16'(BASE_LAT) + extra);
      e.addr = reqAddr;
      e.wr   = (reqCmd == 2'b10);
      e.data = e.wr ? reqWdata : mMem[reqAddr];
      if (e.wr) mMem[reqAddr] = reqWdata;
      if (reqNeedResp) begin
        if (mq.size() == 0) mq.push_back(e);
        else begin
          p = mq.size();
          while (p > 1 && !(le16(mq[p-1].rdy, e.rdy) || mq[p-1].addr == e.addr)) p--;
          mq.insert(p, e);
        end
      end
    end
    if (rv && rspReady) void'(mq.pop_front());
    if (rv && !rspReady) begin mWait = 1'b1; sawRefuse++; end
    else if (rspRetry) mWait = 1'b0;
    if (acc && legal && (int'(reqSize) * BYTE_COST) != 0) mBusy = int'(reqSize) * BYTE_COST;
    else if (busyNow) mBusy--;
    if (endNow) begin mRetry = owedPre; mOwed = 1'b0; end
    else begin mRetry = 1'b0; mOwed = owedPre; end
    mErr  = acc && !legal;
    mNow  = mNow + 16'd1;
    mLfsr = {mLfsr[14:0], mLfsr[15] ^ mLfsr[13] ^ mLfsr[12] ^ mLfsr[10]};
  endtask

  task automatic tick();
    if (autoRsp) begin
      rspReady = ($urandom % 4) != 0;
      rspRetry = ($urandom % 3) == 0;
    end
    modelStep();
    @(negedge clk);
    compareAll();
  endtask

  task automatic sendReq(input logic [1:0] cmd, input logic [ADDR_W-1:0] a,
                         input logic [DATA_W-1:0] d, input logic [SIZE_W-1:0] s,
                         input bit need, input logic [DELAY_W-1:0] dl);
    bit acc;
    reqValid = 1'b1; reqCmd = cmd; reqAddr = a; reqWdata = d;
    reqSize = s; reqNeedResp = need; reqDelay = dl;
    for (int n = 0; n < 200; n++) begin
      acc = mReady();
      tick();
      if (acc) break;
    end
    reqValid = 1'b0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finishRun();
  end

  initial begin
    int lowCnt;
    logic [ADDR_W-1:0] order[$];
    logic lastWr;
    rstN = 1'b0; reqValid = 1'b0; reqCmd = 2'b01; reqAddr = '0; reqWdata = '0;
    reqSize = '0; reqNeedResp = 1'b0; reqDelay = '0; rspReady = 1'b1; rspRetry = 1'b0;
    mBusy = 0; mOwed = 0; mRetry = 0; mErr = 0; mWait = 0;
    mNow = 16'd0; mLfsr = 16'hACE1;
    for (int i = 0; i < 16; i++) mMem[i] = '0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    // reset state (R2, R10)
    chk(reqReady == 1'b1, "R2 reset reqReady", 64'(reqReady), 64'd1);
    chk(drained == 1'b1, "R10 reset drained", 64'(drained), 64'd1);
    chk(rspValid == 1'b0, "R9 reset rspValid", 64'(rspValid), 64'd0);
    compareAll();

    // zero-size write then read of same word (R4, R7)
    sendReq(2'b10, 4'd3, 32'hCAFE_0003, 4'd0, 1'b1, 8'd2);
    chk(reqReady == 1'b1, "R4 zero size keeps ready", 64'(reqReady), 64'd1);
    sendReq(2'b01, 4'd3, 32'h0, 4'd0, 1'b1, 8'd0);
    repeat (20) tick();

    // busy duration (R4) then refusal and retry strobe (R3, R5)
    autoRsp = 1'b0; rspReady = 1'b1; rspRetry = 1'b0;
    sendReq(2'b10, 4'd7, 32'h1234_5678, 4'd4, 1'b0, 8'd0);
    lowCnt = 0;
    while (!reqReady && lowCnt < 100) begin lowCnt++; tick(); end
    chk(lowCnt == 4 * BYTE_COST, "R4 busy length", 64'(lowCnt), 64'(4 * BYTE_COST));
    sendReq(2'b01, 4'd1, 32'h0, 4'd5, 1'b0, 8'd0);
    sendReq(2'b01, 4'd7, 32'h0, 4'd1, 1'b1, 8'd0);
    repeat (20) tick();
    chk(sawRetry > 0, "R5 retry strobe seen", 64'(sawRetry), 64'd1);

    // illegal commands (R1)
    sendReq(2'b00, 4'd2, 32'hDEAD, 4'd3, 1'b1, 8'd0);
    sendReq(2'b11, 4'd2, 32'hBEEF, 4'd3, 1'b1, 8'd0);
    tick();
    chk(sawErr == 2, "R1 error strobes", 64'(sawErr), 64'd2);
    chk(drained == 1'b1, "R1 illegal not queued", 64'(drained), 64'd1);

    // same-address ordering (R8): expect 9, 6, 5, 5(write)
    sendReq(2'b01, 4'd9, 32'h0, 4'd0, 1'b1, 8'd100);
    sendReq(2'b01, 4'd5, 32'h0, 4'd0, 1'b1, 8'd40);
    sendReq(2'b10, 4'd5, 32'h5555, 4'd0, 1'b1, 8'd10);
    sendReq(2'b01, 4'd6, 32'h0, 4'd0, 1'b1, 8'd0);
    for (int n = 0; n < 200 && order.size() < 4; n++) begin
      if (rspValid) begin order.push_back(rspAddr); lastWr = rspIsWrite; end
      tick();
    end
    chk(order.size() == 4, "R8 response count", 64'(order.size()), 64'd4);
    if (order.size() == 4) begin
      chk(order[0] == 4'd9, "R8 first", 64'(order[0]), 64'd9);
      chk(order[1] == 4'd6, "R8 second", 64'(order[1]), 64'd6);
      chk(order[2] == 4'd5 && order[3] == 4'd5 && lastWr, "R8 same address kept behind",
          64'({order[2], order[3], lastWr}), 64'({4'd5, 4'd5, 1'b1}));
    end

    // response refusal and retry (R9)
    rspReady = 1'b0;
    sendReq(2'b01, 4'd3, 32'h0, 4'd0, 1'b1, 8'd0);
    for (int n = 0; n < 40 && !rspValid; n++) tick();
    tick();
    repeat (3) begin
      chk(rspValid == 1'b0, "R9 silent after refusal", 64'(rspValid), 64'd0);
      tick();
    end
    rspRetry = 1'b1; tick(); rspRetry = 1'b0;
    chk(rspValid == 1'b1, "R9 reoffered after retry", 64'(rspValid), 64'd1);
    chk(rspData == 32'hCAFE_0003, "R7 read data", 64'(rspData), 64'hCAFE_0003);
    rspReady = 1'b1; tick();

    // full queue (R11) then drain (R10)
    rspReady = 1'b0;
    for (int n = 0; n < QDEPTH; n++) sendReq(2'b01, 4'(n), 32'h0, 4'd0, 1'b1, 8'd200);
    chk(reqReady == 1'b0, "R11 full queue refuses", 64'(reqReady), 64'd0);
    reqValid = 1'b1; reqSize = 4'd0; tick(); reqValid = 1'b0;
    chk(drained == 1'b0, "R10 not drained when full", 64'(drained), 64'd0);
    rspReady = 1'b1;
    for (int n = 0; n < 400 && !drained; n++) tick();
    chk(drained == 1'b1, "R10 drained after emptying", 64'(drained), 64'd1);

    // random mix: collisions of insert/pop and late refusal/busy end
    autoRsp = 1'b1;
    for (int n = 0; n < 4000; n++) begin
      bit acc;
      if (!reqValid && ($urandom % 3) != 0) begin
        reqValid    = 1'b1;
        reqCmd      = (($urandom % 10) == 0) ? 2'(($urandom % 2) * 3) : 2'(1 + ($urandom % 2));
        reqAddr     = 4'($urandom % 6);
        reqWdata    = $urandom;
        reqSize     = 4'($urandom % 4);
        reqNeedResp = ($urandom % 5) != 0;
        reqDelay    = 8'($urandom % 24);
      end
      acc = reqValid && mReady();
      tick();
      if (acc) reqValid = 1'b0;
    end
    reqValid = 1'b0; rspReady = 1'b1; autoRsp = 1'b0; rspRetry = 1'b1;
    for (int n = 0; n < 400 && !drained; n++) tick();
    rspRetry = 1'b0;
    chk(sawRefuse > 0, "R9 refusals exercised", 64'(sawRefuse), 64'd1);
    chk(drained == 1'b1, "R10 final drained", 64'(drained), 64'd1);
    finishRun();
  end
endmodule